// File: doc/BRIEF.md
# Alternating Stop-and-Go Keystream Generator

This block produces one keystream bit per enabled step from three linear feedback shift registers of different lengths. A steering register advances on every enabled step. The bit it presents before that step decides which one of two data registers advances. The other data register holds. The keystream bit is the exclusive OR of the two data registers' output bits.

Software or a neighbouring block loads the three registers from a seed word with a one-cycle load strobe. It then raises the step enable for as many cycles as keystream bits are wanted. Each result leaves through a registered output with a valid flag. Each register has a fixed primitive trinomial chosen from its length parameter. A seed of all zeros is replaced by the value 1, so no register can lock up.

Top module: `asg_keystream`

## Requirements
- R1: After synchronous reset, `ks_valid` and `ks_bit` are 0. Each of the three registers holds the value 1.
- R2: The steering register advances once on every cycle with `step_en` high and `load` low.
- R3: On a step where the steering register's output bit (bit 0), taken before that step's shift, is 1, data register A advances. If that bit is 0, register A holds.
- R4: On a step where the steering register's pre-shift output bit is 0, data register B advances. If that bit is 1, register B holds.
- R5: In the cycle after each step, `ks_valid` is 1 and `ks_bit` equals bit 0 of register A XOR bit 0 of register B, both taken after that step.
- R6: While `step_en` is low, all three registers keep their state and `ks_valid` is 0 in the following cycle.
- R7: A seed field of all zeros loads the value 1 into its register. Any other seed value is loaded unchanged.
- R8: `load` takes priority over `step_en`. In the cycle after a load, no register has advanced and `ks_valid` is 0.
- R9: Every register shifts toward bit 0, bit 0 is its output, and the new top bit is bit 0 XOR bit k. For x^n+x^k+1 the defaults use k=3 for length 5 (steering), k=6 for length 7 (A) and k=5 for length 9 (B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load the three seed fields this cycle |
| seed_ctl | input | LEN_CTL | Seed for the steering register |
| seed_a | input | LEN_A | Seed for data register A |
| seed_b | input | LEN_B | Seed for data register B |
| step_en | input | 1 | Advance the generator by one step |
| ks_bit | output | 1 | Registered keystream bit |
| ks_valid | output | 1 | High one cycle after each step |

## Verification
A load and a step request can arrive in the same cycle. The bench raises both `load` and `step_en` together. It then expects `ks_valid` low in the next cycle, followed by a keystream that starts exactly at the new seed with no step lost or added. Holding and advancing also meet when `step_en` toggles irregularly. Idle gaps are placed between steps, and the bench checks that the reference sequence continues unbroken across each gap.

// File: rtl/asg_pkg.sv
package asg_pkg;
  // Exponent k of a primitive trinomial x^n + x^k + 1 for length n; 0 = unsupported.
  function automatic int trinomial_tap(input int len);
    case (len)
      3:  return 2;
      4:  return 3;
      5:  return 3;
      6:  return 5;
      7:  return 6;
      9:  return 5;
      10: return 7;
      11: return 9;
      15: return 14;
      17: return 14;
      18: return 11;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/asg_lfsr_cell.sv
module asg_lfsr_cell #(
  parameter int LEN = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           adv,
  output logic [LEN-1:0] state,
  output logic [LEN-1:0] state_nxt
);
  import asg_pkg::*;
  localparam int TAP = trinomial_tap(LEN);
  localparam logic [LEN-1:0] ONE = {{(LEN-1){1'b0}}, 1'b1};

  generate
    if (TAP == 0) begin : g_bad_len
      $error("asg_lfsr_cell: no primitive trinomial for this length");
    end
  endgenerate

  function automatic logic [LEN-1:0] shift_once(input logic [LEN-1:0] s);
    return {s[0] ^ s[TAP], s[LEN-1:1]};
  endfunction

  function automatic logic [LEN-1:0] fix_seed(input logic [LEN-1:0] s);
    return (s == '0) ? ONE : s;
  endfunction

  assign state_nxt = shift_once(state);

  always_ff @(posedge clk) begin
    if (rst)       state <= ONE;
    else if (load) state <= fix_seed(seed);
    else if (adv)  state <= state_nxt;
  end
endmodule

// File: rtl/asg_steer.sv
module asg_steer (
  input  logic load,
  input  logic step_en,
  input  logic ctl_bit,
  output logic adv_ctl,
  output logic adv_a,
  output logic adv_b
);
  assign adv_ctl = step_en & ~load;
  assign adv_a   = adv_ctl & ctl_bit;
  assign adv_b   = adv_ctl & ~ctl_bit;
endmodule

// File: rtl/asg_outreg.sv
module asg_outreg (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic a_post,
  input  logic b_post,
  output logic ks_bit,
  output logic ks_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= fire;
      if (fire) ks_bit <= a_post ^ b_post;
    end
  end
endmodule

// File: rtl/asg_keystream.sv
module asg_keystream #(
  parameter int LEN_CTL = 5,
  parameter int LEN_A   = 7,
  parameter int LEN_B   = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [LEN_CTL-1:0] seed_ctl,
  input  logic [LEN_A-1:0]   seed_a,
  input  logic [LEN_B-1:0]   seed_b,
  input  logic               step_en,
  output logic               ks_bit,
  output logic               ks_valid
);
  generate
    if (LEN_CTL == LEN_A || LEN_CTL == LEN_B || LEN_A == LEN_B) begin : g_len_clash
      $error("asg_keystream: register lengths must all differ");
    end
  endgenerate

  logic [LEN_CTL-1:0] ctl_state, ctl_nxt;
  logic [LEN_A-1:0]   a_state, a_nxt;
  logic [LEN_B-1:0]   b_state, b_nxt;
  logic adv_ctl, adv_a, adv_b;
  logic ctl_bit, a_post, b_post;

  assign ctl_bit = ctl_state[0];

  asg_steer steer_i (
    .load(load), .step_en(step_en), .ctl_bit(ctl_bit),
    .adv_ctl(adv_ctl), .adv_a(adv_a), .adv_b(adv_b)
  );

  asg_lfsr_cell #(.LEN(LEN_CTL)) ctl_i (
    .clk(clk), .rst(rst), .load(load), .seed(seed_ctl), .adv(adv_ctl),
    .state(ctl_state), .state_nxt(ctl_nxt)
  );

  asg_lfsr_cell #(.LEN(LEN_A)) a_i (
    .clk(clk), .rst(rst), .load(load), .seed(seed_a), .adv(adv_a),
    .state(a_state), .state_nxt(a_nxt)
  );

  asg_lfsr_cell #(.LEN(LEN_B)) b_i (
    .clk(clk), .rst(rst), .load(load), .seed(seed_b), .adv(adv_b),
    .state(b_state), .state_nxt(b_nxt)
  );

  assign a_post = adv_a ? a_nxt[0] : a_state[0];
  assign b_post = adv_b ? b_nxt[0] : b_state[0];

  asg_outreg out_i (
    .clk(clk), .rst(rst), .fire(adv_ctl), .a_post(a_post), .b_post(b_post),
    .ks_bit(ks_bit), .ks_valid(ks_valid)
  );
endmodule

// File: rtl/asg_keystream_chk.sv
module asg_keystream_chk #(
  parameter int LEN_CTL = 5,
  parameter int LEN_A   = 7,
  parameter int LEN_B   = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               load,
  input logic               step_en,
  input logic [LEN_CTL-1:0] ctl_state,
  input logic [LEN_A-1:0]   a_state,
  input logic [LEN_B-1:0]   b_state,
  input logic               ks_bit,
  input logic               ks_valid
);
  AST_CTL_MOVES: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load) |=> ctl_state != $past(ctl_state)); // R2
  AST_A_HOLDS_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load && !ctl_state[0]) |=> $stable(a_state)); // R3
  AST_B_HOLDS_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load && ctl_state[0]) |=> $stable(b_state)); // R4
  AST_KS_MATCHES: assert property (@(posedge clk) disable iff (rst)
    ks_valid |-> ks_bit == (a_state[0] ^ b_state[0])); // R5
  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load) |=> ks_valid); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load) |=> ($stable(ctl_state) && $stable(a_state) && $stable(b_state) && !ks_valid)); // R6
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctl_state != '0) && (a_state != '0) && (b_state != '0)); // R7
  AST_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    load |=> !ks_valid); // R8
endmodule

bind asg_keystream asg_keystream_chk #(
  .LEN_CTL(LEN_CTL), .LEN_A(LEN_A), .LEN_B(LEN_B)
) chk_i (
  .clk(clk), .rst(rst), .load(load), .step_en(step_en),
  .ctl_state(ctl_state), .a_state(a_state), .b_state(b_state),
  .ks_bit(ks_bit), .ks_valid(ks_valid)
);

// File: tb/asg_keystream_tb.sv
module asg_keystream_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LC = 5, LA = 7, LB = 9;
  localparam int KC = 3, KA = 6, KB = 5;

  logic clk = 0, rst = 1, load = 0, step_en = 0;
  logic [LC-1:0] seed_ctl = '0;
  logic [LA-1:0] seed_a = '0;
  logic [LB-1:0] seed_b = '0;
  logic ks_bit, ks_valid;

  int checks = 0, errors = 0;
  int mc, ma, mb;

  always #(CLK_PERIOD/2) clk = ~clk;

  asg_keystream #(.LEN_CTL(LC), .LEN_A(LA), .LEN_B(LB)) dut_i (
    .clk(clk), .rst(rst), .load(load), .seed_ctl(seed_ctl), .seed_a(seed_a),
    .seed_b(seed_b), .step_en(step_en), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  // Reference shift: new top bit is bit 0 XOR bit k; value moves toward bit 0.
  function automatic int ref_adv(input int s, input int n, input int k);
    int top;
    top = (s ^ (s >> k)) & 1;
    return (s >> 1) | (top << (n - 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic one_step(input string req);
    int e;
    step_en = 1;
    if ((mc & 1) == 1) ma = ref_adv(ma, LA, KA);
    else               mb = ref_adv(mb, LB, KB);
    mc = ref_adv(mc, LC, KC);
    e = (ma ^ mb) & 1;
    @(negedge clk);
    step_en = 0;
    check({req, " valid"}, int'(ks_valid), 1);
    check({req, " bit"}, int'(ks_bit), e);
  endtask

  task automatic do_load(input int c, input int a, input int b, input logic with_step);
    seed_ctl = LC'(c); seed_a = LA'(a); seed_b = LB'(b);
    load = 1; step_en = with_step;
    mc = (c == 0) ? 1 : c;
    ma = (a == 0) ? 1 : a;
    mb = (b == 0) ? 1 : b;
    @(negedge clk);
    load = 0; step_en = 0;
    check("R8 valid after load", int'(ks_valid), 0);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    mc = 1; ma = 1; mb = 1;
    check("R1 reset valid", int'(ks_valid), 0);
    check("R1 reset bit", int'(ks_bit), 0);
  endtask

  task automatic t_run_from_reset();
    for (int i = 0; i < 40; i++) one_step("R1 R2 R3 R4 R5 R9 from reset");
  endtask

  task automatic t_seeded();
    do_load(5'h13, 7'h2d, 9'h15a, 1'b0);
    for (int i = 0; i < 80; i++) one_step("R3 R4 R5 seeded");
  endtask

  task automatic t_gaps();
    do_load(5'h0a, 7'h61, 9'h0f3, 1'b0);
    for (int i = 0; i < 30; i++) begin
      one_step("R6 gapped step");
      for (int g = 0; g < (i % 3); g++) begin
        @(negedge clk);
        check("R6 idle valid", int'(ks_valid), 0);
      end
    end
  endtask

  task automatic t_zero_seed();
    do_load(0, 0, 0, 1'b0);
    for (int i = 0; i < 30; i++) one_step("R7 zero seed");
    do_load(0, 7'h44, 0, 1'b0);
    for (int i = 0; i < 30; i++) one_step("R7 partial zero seed");
  endtask

  task automatic t_load_with_step();
    for (int i = 0; i < 5; i++) one_step("R8 warm up");
    do_load(5'h1f, 7'h7f, 9'h1ff, 1'b1);
    for (int i = 0; i < 40; i++) one_step("R8 after load with step");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_run_from_reset();
    t_seeded();
    t_gaps();
    t_zero_seed();
    t_load_with_step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule